// File: doc/BRIEF.md
# Dual-Target Two-Wire Serial Slave

This block is a slave engine for a two-wire serial bus with a clock line and an open-drain data line. One physical port serves two logical targets. The first is a byte-wide memory that takes a two-byte address. The second is a small companion register file that takes a one-byte address. The block watches the oversampled bus lines for START and STOP. It shifts in the slave address byte and checks it against the target identifiers and two strap pins. It then runs the address and data phases for the chosen target and answers each byte with ACK or NACK. The data line is driven through an output enable: when `sdaOe` is high the pad pulls the line low.

The memory array and the register contents sit outside the block. The memory side sees an address, a write byte, a one-cycle write strobe and a one-cycle read strobe. Read data is expected to be valid in the same cycle as the read strobe, for the address then on `memAddr`. The register side has the same shape. Each target keeps its own address pointer, and that pointer moves forward by one after every data byte.

Top module: `twoWireDualSlave`

## Requirements
- R1: A START seen in any state, including a repeated START in the middle of a transfer, returns the engine to the slave-address phase. A STOP returns it to idle. In idle, clocked bytes get no ACK.
- R2: In the slave address byte, bits 7:4 = 1010b select the memory target and 1101b select the register target. Bits 2:1 must equal `strapAddr`, and bit 3 is ignored. On a match the slave ACKs. On any mismatch it does not ACK and ignores the bus until the next START or STOP.
- R3: Bit 0 of the slave address byte sets the direction: 1 is a read, 0 is a write.
- R4: A memory write first takes the address high byte and then the low byte, each ACKed. The pointer becomes the low MEM_AW bits of {high, low} only once the low byte arrives.
- R5: A write data byte is received MSB first and ACKed. In the cycle after its eighth bit, the target's write strobe pulses for exactly one cycle with the current pointer on the address port. The pointer then advances by one.
- R6: The memory pointer wraps from all ones to zero.
- R7: A register address byte in the range 00h to 18h is ACKed and loaded. A larger value is NACKed, the pointer is left unchanged, and the rest of the transfer is ignored until START or STOP.
- R8: The register pointer advances after each data byte and wraps from 18h to 00h.
- R9: For each read byte, the target's read strobe pulses for one cycle and the byte at the current pointer is shifted out MSB first. The pointer then advances. A master ACK continues with the next byte. A master NACK ends the read and leaves SDA released until the next START or STOP.
- R10: Register transfers never change the memory pointer or pulse a memory strobe, and memory transfers never pulse a register strobe.
- R11: The slave changes `sdaOe` only while SCL is low, and it releases SDA once the ACK clock has ended.
- R12: After reset, SDA is released, every strobe is low and both pointers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaOe | output | 1 | High pulls the data line low |
| strapAddr | input | 2 | Device-select strap pins |
| memAddr | output | MEM_AW | Memory pointer |
| memWrData | output | 8 | Byte to write into the memory |
| memWrStb | output | 1 | One-cycle memory write strobe |
| memRdStb | output | 1 | One-cycle memory read strobe |
| memRdData | input | 8 | Memory byte at `memAddr` |
| regAddr | output | REG_AW | Register pointer |
| regWrData | output | 8 | Byte to write into the register file |
| regWrStb | output | 1 | One-cycle register write strobe |
| regRdStb | output | 1 | One-cycle register read strobe |
| regRdData | input | 8 | Register byte at `regAddr` |

## Verification
The hardest states to reach are the mid-transfer interruptions. These are a repeated START placed right after the memory address bytes, so that the read must continue from the freshly loaded pointer, and the bytes that follow an out-of-range register address or a master NACK, which the slave must leave untouched. The bench master reaches them with directed sequences. It clocks extra bytes after each abort and drives SDA itself, so that any ACK or data from the slave would show on the bus. Pointer wrap is reached by loading addresses just below the end of each range. Random mixes of the four transfer kinds then run on top of these cases.

// File: rtl/twsPkg.sv
package twsPkg;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_MHI, S_MLO, S_RADR, S_WDAT, S_RDAT, S_ACKO, S_ACKI, S_SKIP
  } phase_e;

  // strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic rxShift;
    logic latchHi;
    logic latchMemAdr;
    logic latchRegAdr;
    logic memWr;
    logic regWr;
    logic loadTx;
    logic txFromMem;
    logic shiftTx;
    logic oeAck;
    logic oeRelease;
  } ctlStb_t;

endpackage

// File: rtl/twsSync.sv
module twsSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  logic [STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclLvl  = sclPipe[STAGES-1];
  assign sdaLvl  = sdaPipe[STAGES-1];
  assign sclRise = sclLvl & ~sclPrev;
  assign sclFall = ~sclLvl & sclPrev;
  assign startEv = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopEv  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;
endmodule

// File: rtl/twsControl.sv
module twsControl
  import twsPkg::*;
#(
  parameter int     REG_LAST = 24,
  parameter logic [3:0] MEM_ID = 4'b1010,
  parameter logic [3:0] REG_ID = 4'b1101
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       sdaLvl,
  input  logic [7:0] rxByte,
  input  logic [1:0] strapAddr,
  output ctlStb_t    ctl
);
  phase_e     phase, phaseN, nextPh, nextPhN;
  logic [3:0] bitCnt, bitCntN;
  logic       tgtMem, tgtMemN;
  logic       mAck, mAckN;
  logic       idMem, idReg, strapOk;

  assign idMem   = rxByte[7:4] == MEM_ID;
  assign idReg   = rxByte[7:4] == REG_ID;
  assign strapOk = rxByte[2:1] == strapAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= S_IDLE;
      nextPh <= S_IDLE;
      bitCnt <= '0;
      tgtMem <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      phase  <= phaseN;
      nextPh <= nextPhN;
      bitCnt <= bitCntN;
      tgtMem <= tgtMemN;
      mAck   <= mAckN;
    end
  end

  always_comb begin
    ctl     = '0;
    phaseN  = phase;
    nextPhN = nextPh;
    bitCntN = bitCnt;
    tgtMemN = tgtMem;
    mAckN   = mAck;
    if (stopEv) begin
      phaseN        = S_IDLE;
      ctl.oeRelease = 1'b1;
    end else if (startEv) begin
      phaseN        = S_DEV;
      bitCntN       = '0;
      ctl.oeRelease = 1'b1;
    end else begin
      case (phase)
        S_DEV, S_MHI, S_MLO, S_RADR, S_WDAT: begin
          if (sclRise && bitCnt < 4'd8) begin
            ctl.rxShift = 1'b1;
            bitCntN     = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            bitCntN   = '0;
            phaseN    = S_ACKO;
            ctl.oeAck = 1'b1;
            case (phase)
              S_DEV: begin
                if ((idMem || idReg) && strapOk) begin
                  tgtMemN = idMem;
                  if (rxByte[0])  nextPhN = S_RDAT;
                  else if (idMem) nextPhN = S_MHI;
                  else            nextPhN = S_RADR;
                end else begin
                  phaseN    = S_SKIP;
                  ctl.oeAck = 1'b0;
                end
              end
              S_MHI: begin
                ctl.latchHi = 1'b1;
                nextPhN     = S_MLO;
              end
              S_MLO: begin
                ctl.latchMemAdr = 1'b1;
                nextPhN         = S_WDAT;
              end
              S_RADR: begin
                if (rxByte <= 8'(REG_LAST)) begin
                  ctl.latchRegAdr = 1'b1;
                  nextPhN         = S_WDAT;
                end else begin
                  phaseN    = S_SKIP;
                  ctl.oeAck = 1'b0;
                end
              end
              default: begin
                ctl.memWr = tgtMem;
                ctl.regWr = ~tgtMem;
                nextPhN   = S_WDAT;
              end
            endcase
          end
        end
        S_ACKO: begin
          if (sclFall) begin
            phaseN = nextPh;
            if (nextPh == S_RDAT) begin
              ctl.loadTx    = 1'b1;
              ctl.txFromMem = tgtMem;
            end else begin
              ctl.oeRelease = 1'b1;
            end
          end
        end
        S_RDAT: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              bitCntN       = '0;
              phaseN        = S_ACKI;
              ctl.oeRelease = 1'b1;
            end else begin
              bitCntN     = bitCnt + 4'd1;
              ctl.shiftTx = 1'b1;
            end
          end
        end
        S_ACKI: begin
          if (sclRise) mAckN = ~sdaLvl;
          else if (sclFall) begin
            if (mAck) begin
              phaseN        = S_RDAT;
              ctl.loadTx    = 1'b1;
              ctl.txFromMem = tgtMem;
            end else begin
              phaseN = S_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twsDatapath.sv
module twsDatapath
  import twsPkg::*;
#(
  parameter int MEM_AW   = 16,
  parameter int REG_AW   = 5,
  parameter int REG_LAST = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           ctl,
  input  logic              sdaLvl,
  input  logic [7:0]        memRdData,
  input  logic [7:0]        regRdData,
  output logic [7:0]        rxByte,
  output logic              sdaOe,
  output logic [MEM_AW-1:0] memAddr,
  output logic [REG_AW-1:0] regAddr
);
  localparam logic [REG_AW-1:0] REG_END = REG_AW'(REG_LAST);

  logic [7:0]  hiByte, txShift, txSrc;
  logic [15:0] adrFull;
  logic        memStep, regStep;

  assign adrFull = {hiByte, rxByte};
  assign txSrc   = ctl.txFromMem ? memRdData : regRdData;
  assign memStep = ctl.memWr | (ctl.loadTx & ctl.txFromMem);
  assign regStep = ctl.regWr | (ctl.loadTx & ~ctl.txFromMem);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      hiByte  <= '0;
      txShift <= '0;
    end else begin
      if (ctl.rxShift) rxByte <= {rxByte[6:0], sdaLvl};
      if (ctl.latchHi) hiByte <= rxByte;
      if (ctl.loadTx)       txShift <= txSrc;
      else if (ctl.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                memAddr <= '0;
    else if (ctl.latchMemAdr) memAddr <= adrFull[MEM_AW-1:0];
    else if (memStep)         memAddr <= memAddr + MEM_AW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                regAddr <= '0;
    else if (ctl.latchRegAdr) regAddr <= rxByte[REG_AW-1:0];
    else if (regStep)         regAddr <= (regAddr == REG_END) ? '0 : regAddr + REG_AW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sdaOe <= 1'b0;
    else if (ctl.oeRelease) sdaOe <= 1'b0;
    else if (ctl.oeAck)     sdaOe <= 1'b1;
    else if (ctl.loadTx)    sdaOe <= ~txSrc[7];
    else if (ctl.shiftTx)   sdaOe <= ~txShift[6];
  end
endmodule

// File: rtl/twoWireDualSlave.sv
module twoWireDualSlave
  import twsPkg::*;
#(
  parameter int MEM_AW   = 16,
  parameter int REG_AW   = 5,
  parameter int REG_LAST = 24,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic [1:0]        strapAddr,
  output logic [MEM_AW-1:0] memAddr,
  output logic [7:0]        memWrData,
  output logic              memWrStb,
  output logic              memRdStb,
  input  logic [7:0]        memRdData,
  output logic [REG_AW-1:0] regAddr,
  output logic [7:0]        regWrData,
  output logic              regWrStb,
  output logic              regRdStb,
  input  logic [7:0]        regRdData
);
  logic    sclLvl, sdaLvl, sclRise, sclFall, startEv, stopEv;
  logic [7:0] rxByte;
  ctlStb_t ctl;

  twsSync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  twsControl #(.REG_LAST(REG_LAST)) u_ctl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .sdaLvl(sdaLvl), .rxByte(rxByte),
    .strapAddr(strapAddr), .ctl(ctl)
  );

  twsDatapath #(.MEM_AW(MEM_AW), .REG_AW(REG_AW), .REG_LAST(REG_LAST)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaLvl(sdaLvl),
    .memRdData(memRdData), .regRdData(regRdData), .rxByte(rxByte),
    .sdaOe(sdaOe), .memAddr(memAddr), .regAddr(regAddr)
  );

  assign memWrData = rxByte;
  assign regWrData = rxByte;
  assign memWrStb  = ctl.memWr;
  assign regWrStb  = ctl.regWr;
  assign memRdStb  = ctl.loadTx & ctl.txFromMem;
  assign regRdStb  = ctl.loadTx & ~ctl.txFromMem;

  // sclLvl is only consumed through its edges
  logic unusedLvl;
  assign unusedLvl = sclLvl;
endmodule

// File: rtl/twsChecker.sv
module twsChecker #(
  parameter int MEM_AW   = 16,
  parameter int REG_AW   = 5,
  parameter int REG_LAST = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic [MEM_AW-1:0] memAddr,
  input logic              memWrStb,
  input logic              memRdStb,
  input logic [REG_AW-1:0] regAddr,
  input logic              regWrStb,
  input logic              regRdStb
);
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  p_memwr_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWrStb |=> !memWrStb);

  p_regwr_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    regWrStb |=> !regWrStb);

  p_memwr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWrStb |=> memAddr == $past(memAddr) + MEM_AW'(1));

  p_rd_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memRdStb || regRdStb) |=> !(memRdStb || regRdStb));

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memWrStb, memRdStb, regWrStb, regRdStb}));

  p_reg_keeps_mem_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrStb || regRdStb) |=> $stable(memAddr));

  p_regaddr_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    int'(regAddr) <= REG_LAST);
endmodule

bind twoWireDualSlave twsChecker #(.MEM_AW(MEM_AW), .REG_AW(REG_AW), .REG_LAST(REG_LAST)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .memAddr(memAddr),
  .memWrStb(memWrStb), .memRdStb(memRdStb), .regAddr(regAddr),
  .regWrStb(regWrStb), .regRdStb(regRdStb)
);

// File: tb/twoWireDualSlave_tb.sv
`timescale 1ns/1ps
module twoWireDualSlave_tb;
  localparam int Q = 6;
  localparam logic [1:0] STRAP = 2'b10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, memWrStb, memRdStb, regWrStb, regRdStb;
  logic [15:0] memAddr;
  logic [4:0]  regAddr;
  logic [7:0]  memWrData, regWrData, memRdData, regRdData;
  wire  sdaBus = sdaM & ~sdaOe;

  logic [7:0] devMem [256];
  logic [7:0] devReg [32];
  logic [7:0] expMem [256];
  logic [7:0] expReg [32];
  logic [15:0] expAddr = '0;
  logic [4:0]  expRegAdr = '0;
  int nChecks = 0, nFail = 0, holdErr = 0;
  int memWrCnt = 0, memRdCnt = 0, regWrCnt = 0, regRdCnt = 0;

  always #2 clk = ~clk;

  twoWireDualSlave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .strapAddr(STRAP), .memAddr(memAddr), .memWrData(memWrData),
    .memWrStb(memWrStb), .memRdStb(memRdStb), .memRdData(memRdData),
    .regAddr(regAddr), .regWrData(regWrData), .regWrStb(regWrStb),
    .regRdStb(regRdStb), .regRdData(regRdData)
  );

  assign memRdData = devMem[memAddr[7:0]];
  assign regRdData = devReg[regAddr];

  always @(posedge clk) begin
    if (memWrStb) begin devMem[memAddr[7:0]] <= memWrData; memWrCnt++; end
    if (regWrStb) begin devReg[regAddr] <= regWrData; regWrCnt++; end
    if (memRdStb) memRdCnt++;
    if (regRdStb) regRdCnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] regNext(input logic [4:0] a);
    return (a == 5'h18) ? 5'h00 : a + 5'd1;
  endfunction

  function automatic logic [7:0] devByte(input bit isMem, input bit rd, input logic [1:0] strap, input bit b3);
    return {isMem ? 4'b1010 : 4'b1101, b3, strap, rd};
  endfunction

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic clk1(input logic b, output logic s);
    sdaM = b; waitQ(); sclM = 1'b1; waitQ(); s = sdaBus; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, input bit chkRel, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk1(b[i], s);
    clk1(1'b1, s);
    ack = ~s;
    if (chkRel && sdaOe) holdErr++;   // R11 release after ACK clock
  endtask

  task automatic readByte(input bit ackM, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk1(1'b1, s); b[i] = s; end
    clk1(~ackM, s);
  endtask

  task automatic memWrite(input logic [15:0] adr, input int n);
    bit ack;
    logic [7:0] d;
    busStart();
    writeByte(devByte(1, 0, STRAP, 0), 1, ack); chk(ack, "R2 mem id ack", ack, 1);
    writeByte(adr[15:8], 1, ack); chk(ack, "R4 addr hi ack", ack, 1);
    writeByte(adr[7:0], 1, ack);  chk(ack, "R4 addr lo ack", ack, 1);
    expAddr = adr;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      writeByte(d, 1, ack); chk(ack, "R5 data ack", ack, 1);
      expMem[expAddr[7:0]] = d;
      expAddr = expAddr + 16'd1;
    end
    busStop();
    chk(memAddr == expAddr, "R5 R6 mem pointer after write", memAddr, expAddr);
  endtask

  task automatic memRead(input bit setAdr, input logic [15:0] adr, input int n);
    bit ack;
    logic [7:0] d;
    busStart();
    if (setAdr) begin
      writeByte(devByte(1, 0, STRAP, 1), 1, ack); chk(ack, "R2 bit3 ignored", ack, 1);
      writeByte(adr[15:8], 1, ack);
      writeByte(adr[7:0], 1, ack);
      expAddr = adr;
      busStart();   // repeated START, R1
    end
    writeByte(devByte(1, 1, STRAP, 0), 0, ack); chk(ack, "R1 R3 read ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      readByte(i < n - 1, d);
      chk(d == expMem[expAddr[7:0]], "R9 mem read data", d, expMem[expAddr[7:0]]);
      expAddr = expAddr + 16'd1;
    end
    readByte(1'b0, d);
    chk(d == 8'hFF, "R9 released after master NACK", d, 8'hFF);
    busStop();
    chk(memAddr == expAddr, "R9 mem pointer after read", memAddr, expAddr);
  endtask

  task automatic regWrite(input logic [4:0] adr, input int n);
    bit ack;
    logic [7:0] d;
    int mw;
    logic [15:0] ma;
    mw = memWrCnt; ma = memAddr;
    busStart();
    writeByte(devByte(0, 0, STRAP, 0), 1, ack); chk(ack, "R2 reg id ack", ack, 1);
    writeByte({3'b0, adr}, 1, ack); chk(ack, "R7 legal reg addr ack", ack, 1);
    expRegAdr = adr;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      writeByte(d, 1, ack); chk(ack, "R5 reg data ack", ack, 1);
      expReg[expRegAdr] = d;
      expRegAdr = regNext(expRegAdr);
    end
    busStop();
    chk(regAddr == expRegAdr, "R8 reg pointer", regAddr, expRegAdr);
    chk(memAddr == ma && memWrCnt == mw, "R10 reg write leaves memory", memAddr, ma);
  endtask

  task automatic regRead(input int n);
    bit ack;
    logic [7:0] d;
    logic [15:0] ma;
    int mr;
    ma = memAddr; mr = memRdCnt;
    busStart();
    writeByte(devByte(0, 1, STRAP, 0), 0, ack); chk(ack, "R3 reg read ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      readByte(i < n - 1, d);
      chk(d == expReg[expRegAdr], "R9 reg read data", d, expReg[expRegAdr]);
      expRegAdr = regNext(expRegAdr);
    end
    busStop();
    chk(regAddr == expRegAdr, "R8 reg pointer after read", regAddr, expRegAdr);
    chk(memAddr == ma && memRdCnt == mr, "R10 reg read leaves memory", memAddr, ma);
  endtask

  initial begin
    bit ack;
    int mw, rw;
    logic [7:0] d;
    void'($urandom(32'h1234abcd));
    for (int i = 0; i < 256; i++) begin devMem[i] = 8'(i) ^ 8'h5a; expMem[i] = 8'(i) ^ 8'h5a; end
    for (int i = 0; i < 32; i++) begin devReg[i] = 8'(i) ^ 8'hc3; expReg[i] = 8'(i) ^ 8'hc3; end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sdaOe && !memWrStb && !memRdStb && !regWrStb && !regRdStb, "R12 reset outputs", sdaOe, 0);
    chk(memAddr == 0 && regAddr == 0, "R12 reset pointers", memAddr, 0);

    memWrite(16'h1234, 4);
    memRead(1, 16'h1234, 4);
    memWrite(16'hFFFE, 3);
    chk(memAddr == 16'h0001, "R6 memory wrap", memAddr, 1);
    memRead(1, 16'hFFFE, 3);

    // R1 repeated START right after one data byte
    busStart();
    writeByte(devByte(1, 0, STRAP, 0), 1, ack);
    writeByte(8'h00, 1, ack); writeByte(8'h40, 1, ack);
    d = 8'h77; writeByte(d, 1, ack); expMem[8'h40] = d; expAddr = 16'h0041;
    busStart();
    writeByte(devByte(1, 1, STRAP, 0), 0, ack); chk(ack, "R1 repeated START read", ack, 1);
    readByte(1'b0, d);
    chk(d == expMem[8'h41], "R1 read continues at pointer", d, expMem[8'h41]);
    expAddr = 16'h0042;
    busStop();

    // R1 bytes in idle after STOP get no ACK
    writeByte(devByte(1, 0, STRAP, 0), 0, ack);
    chk(!ack, "R1 idle ignores bytes", ack, 0);
    busStop();

    // R2 wrong strap and wrong id
    mw = memWrCnt;
    busStart();
    writeByte(devByte(1, 0, ~STRAP, 0), 0, ack); chk(!ack, "R2 strap mismatch NACK", ack, 0);
    writeByte(8'h00, 0, ack); chk(!ack, "R2 ignored after mismatch", ack, 0);
    busStop();
    busStart();
    writeByte({4'b1011, 1'b0, STRAP, 1'b0}, 0, ack); chk(!ack, "R2 unknown id NACK", ack, 0);
    busStop();
    chk(memWrCnt == mw && memAddr == expAddr, "R2 no memory effect", memAddr, expAddr);

    regWrite(5'h17, 3);
    chk(regAddr == 5'h01, "R8 reg wrap", regAddr, 1);
    expRegAdr = 5'h17;
    busStart(); writeByte(devByte(0, 0, STRAP, 0), 1, ack); writeByte(8'h17, 1, ack); busStop();
    regRead(3);

    // R7 out-of-range register address
    rw = regWrCnt;
    busStart();
    writeByte(devByte(0, 0, STRAP, 0), 1, ack);
    writeByte(8'h19, 0, ack); chk(!ack, "R7 addr 19h NACK", ack, 0);
    writeByte(8'h55, 0, ack); chk(!ack, "R7 rest ignored", ack, 0);
    busStop();
    chk(regAddr == expRegAdr && regWrCnt == rw, "R7 pointer unchanged", regAddr, expRegAdr);

    // random mix
    for (int k = 0; k < 10; k++) begin
      case ($urandom_range(0, 3))
        0: memWrite({8'($urandom), 8'($urandom)}, $urandom_range(1, 4));
        1: memRead($urandom_range(0, 1) == 1, {8'($urandom), 8'($urandom)}, $urandom_range(1, 4));
        2: regWrite(5'($urandom_range(0, 24)), $urandom_range(1, 4));
        default: regRead($urandom_range(1, 4));
      endcase
    end

    chk(holdErr == 0, "R11 SDA released after ACK", holdErr, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule